// File: doc/BRIEF.md
# AC-Coupled Boundary-Scan Output Driver

This block drives the pins of differential lanes whose links are AC-coupled while the device is under boundary-scan test. It sits behind a standard JTAG TAP controller and takes from it a decoded boundary-test mode, a flag that is high while the TAP rests in Run-Test/Idle, TCK, the scan strobes for a small dedicated chain of per-port AC/DC select cells, and the stimulus bits that the boundary register's update stage already holds. For every lane it drives a true and a complement output. It also drives a few single-ended boundary pins.

A static level cannot cross a coupling capacitor. For ports marked AC, the two AC test modes therefore add an edge at the pins. In pulse mode the lane polarity flips for as long as the TAP stays in Run-Test/Idle. In train mode the polarity alternates on every falling TCK edge in that state. Ports marked DC, the plain EXTEST mode, and every single-ended pin keep static stimulus levels. When no boundary-test mode is active, the outputs carry the functional data.

Top module: `acjtag_out_driver`

## Requirements
- R1: With mode code 0 (functional), each lane true output equals its functional input bit and each single-ended output equals its functional input bit, regardless of the select bits and Run-Test/Idle.
- R2: With mode code 1 (EXTEST), each lane true output equals its stimulus bit in every TCK cycle, including cycles spent in Run-Test/Idle, for AC and DC ports alike.
- R3: The select cells form a shift chain with scanIn entering port 0's cell and port NUM_PORTS-1's cell driving scanOut. On a rising TCK edge, bsCapture loads each cell from its port's live select bit; otherwise bsShift shifts the chain one place toward scanOut. A falling TCK edge with bsUpdate high copies the chain into the select bits. Select value 1 means AC and 0 means DC.
- R4: While trstN is low, all select bits and chain cells are 0 (DC) and the train phase is non-inverted. After trstN is released, a capture reads back 0 for every port.
- R5: On a port whose select bit is DC, modes 2 (pulse) and 3 (train) give exactly the EXTEST levels, in Run-Test/Idle as well.
- R6: With mode code 2 and the port set to AC, the lane true outputs carry the inverse of the stimulus while the Run-Test/Idle flag is high. The inversion follows the flag with no clock delay.
- R7: With mode code 2, dropping the Run-Test/Idle flag restores true output = stimulus at once.
- R8: With mode code 3 and the port set to AC, the outputs are non-inverted when Run-Test/Idle is entered. After the k-th falling TCK edge in that state they are inverted when k is odd and non-inverted when k is even.
- R9: With mode code 3, leaving Run-Test/Idle restores non-inverted levels at once, whatever the phase was. On the next entry the sequence restarts non-inverted.
- R10: Single-ended outputs equal their stimulus bits in modes 1, 2 and 3 and are never inverted.
- R11: Every lane complement output is the exact inverse of its true output in every mode and state.
- R12: Each port follows its own select bit. Lanes of an AC port toggle while lanes of a DC port stay static under the same mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test-logic reset, active low |
| instrSel | input | 2 | Decoded mode: 0 functional, 1 EXTEST, 2 pulse, 3 train |
| rtiState | input | 1 | High while the TAP is in Run-Test/Idle |
| bsShift | input | 1 | Shift the select chain on the rising TCK edge |
| bsCapture | input | 1 | Load the select chain from the select bits on the rising TCK edge |
| bsUpdate | input | 1 | Copy the chain into the select bits on the falling TCK edge |
| scanIn | input | 1 | Serial data into the select chain |
| scanOut | output | 1 | Serial data out of the select chain |
| laneStim | input | NUM_PORTS*LANES_PER_PORT | Stimulus bit per lane from the boundary update stage |
| laneFunc | input | NUM_PORTS*LANES_PER_PORT | Functional data per lane |
| seStim | input | NUM_SE | Stimulus per single-ended pin |
| seFunc | input | NUM_SE | Functional data per single-ended pin |
| laneP | output | NUM_PORTS*LANES_PER_PORT | True output per lane |
| laneN | output | NUM_PORTS*LANES_PER_PORT | Complement output per lane |
| seOut | output | NUM_SE | Single-ended pin outputs |

## Verification
The lane and single-ended outputs are combinational in the mode, the Run-Test/Idle flag and the stored phase. The bench changes inputs 2 time units after a rising edge and checks the immediate response (R1, R2, R6, R7, R9 at entry and exit) 3 units later, before the next falling edge. The train phase and the select bits change only on a falling edge, so those results are due after that edge, and the bench checks them 2 units after each falling edge, once per edge while in Run-Test/Idle. A chain shift or capture is due at the rising edge on which its strobe is sampled, and scanOut is read 2 units after that edge.

// File: rtl/acjtag_pkg.sv
package acjtag_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC   = 2'd0,
    MODE_EXTEST = 2'd1,
    MODE_PULSE  = 2'd2,
    MODE_TRAIN  = 2'd3
  } bsMode_e;

  // Per-port strobes from control to datapath
  typedef struct packed {
    logic drive;   // boundary stimulus selected instead of functional data
    logic invert;  // lane polarity flipped
  } laneCtl_t;

endpackage

// File: rtl/acjtag_ctrl.sv
module acjtag_ctrl
  import acjtag_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                     tck,
  input  logic                     trstN,
  input  logic [1:0]               instrSel,
  input  logic                     rtiState,
  input  logic                     bsShift,
  input  logic                     bsCapture,
  input  logic                     bsUpdate,
  input  logic                     scanIn,
  output logic                     scanOut,
  output laneCtl_t [NUM_PORTS-1:0] portCtl,
  output logic                     seDrive
);

  bsMode_e mode;
  assign mode = bsMode_e'(instrSel);

  logic [NUM_PORTS-1:0] selChain;
  logic [NUM_PORTS-1:0] chainNext;
  logic [NUM_PORTS-1:0] acSel;
  logic [NUM_PORTS-1:0] trainPhase;
  logic                 bsActive;
  logic                 armed;

  assign bsActive = (mode != MODE_FUNC);
  assign seDrive  = bsActive;

  // Serial path through the select cells: cell 0 takes scanIn
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      chainNext[i] = (i == 0) ? scanIn : selChain[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      selChain <= '0;
    end else if (bsCapture) begin
      selChain <= acSel;
    end else if (bsShift) begin
      selChain <= chainNext;
    end
  end

  assign scanOut = selChain[NUM_PORTS-1];

  // Update stage on the falling edge, as for the other boundary cells
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      acSel <= '0;
    end else if (bsUpdate) begin
      acSel <= selChain;
    end
  end

  // Qualifies history-based checks once a full edge has passed since reset
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic trainOn;
    logic pulseOn;

    assign trainOn = (mode == MODE_TRAIN) && acSel[p];
    assign pulseOn = (mode == MODE_PULSE) && acSel[p];

    // Phase alternates on each falling edge in Run-Test/Idle and rests at 0
    always_ff @(negedge tck or negedge trstN) begin
      if (!trstN) begin
        trainPhase[p] <= 1'b0;
      end else if (trainOn && rtiState) begin
        trainPhase[p] <= ~trainPhase[p];
      end else begin
        trainPhase[p] <= 1'b0;
      end
    end

    assign portCtl[p].drive  = bsActive;
    assign portCtl[p].invert = rtiState && (pulseOn || (trainOn && trainPhase[p]));

    AST_DC_PLAIN: assert property (@(negedge tck) disable iff (!trstN)
      !acSel[p] |-> !portCtl[p].invert); // R5

    AST_FUNC_NO_DRIVE: assert property (@(negedge tck) disable iff (!trstN)
      (mode == MODE_FUNC) |-> (!portCtl[p].drive && !portCtl[p].invert)); // R1

    AST_TRAIN_START_NORMAL: assert property (@(negedge tck) disable iff (!trstN)
      (armed && trainOn && $rose(rtiState)) |-> !trainPhase[p]); // R8

    AST_TRAIN_ALTERNATE: assert property (@(negedge tck) disable iff (!trstN)
      (armed && trainOn && rtiState && $past(trainOn && rtiState))
        |-> (trainPhase[p] != $past(trainPhase[p]))); // R8

    AST_TRAIN_EXIT_NORMAL: assert property (@(negedge tck) disable iff (!trstN)
      (mode == MODE_TRAIN && !rtiState) |-> !portCtl[p].invert); // R9
  end

  AST_RESET_CLEAR: assert property (@(posedge tck)
    !trstN |-> (acSel == '0 && selChain == '0 && trainPhase == '0)); // R4

endmodule

// File: rtl/acjtag_dpath.sv
module acjtag_dpath
  import acjtag_pkg::*;
#(
  parameter int NUM_PORTS      = 2,
  parameter int LANES_PER_PORT = 2,
  parameter int NUM_SE         = 2,
  localparam int NUM_LANES     = NUM_PORTS * LANES_PER_PORT
) (
  input  logic                     tck,
  input  logic                     trstN,
  input  laneCtl_t [NUM_PORTS-1:0] portCtl,
  input  logic                     seDrive,
  input  logic [NUM_LANES-1:0]     laneStim,
  input  logic [NUM_LANES-1:0]     laneFunc,
  input  logic [NUM_SE-1:0]        seStim,
  input  logic [NUM_SE-1:0]        seFunc,
  output logic [NUM_LANES-1:0]     laneP,
  output logic [NUM_LANES-1:0]     laneN,
  output logic [NUM_SE-1:0]        seOut
);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int PORT = i / LANES_PER_PORT;
    logic baseLvl;
    logic trueLvl;

    assign baseLvl  = portCtl[PORT].drive ? laneStim[i] : laneFunc[i];
    assign trueLvl  = baseLvl ^ portCtl[PORT].invert;
    assign laneP[i] = trueLvl;
    assign laneN[i] = ~trueLvl;

    AST_LANE_STATIC: assert property (@(negedge tck) disable iff (!trstN)
      (portCtl[PORT].drive && !portCtl[PORT].invert) |-> (laneP[i] == laneStim[i])); // R2

    AST_LANE_SWAP: assert property (@(negedge tck) disable iff (!trstN)
      portCtl[PORT].invert |-> (laneP[i] != laneStim[i] && laneN[i] == laneStim[i])); // R6
  end

  for (genvar s = 0; s < NUM_SE; s++) begin : g_se
    assign seOut[s] = seDrive ? seStim[s] : seFunc[s];

    AST_SE_NO_INVERT: assert property (@(negedge tck) disable iff (!trstN)
      seDrive |-> (seOut[s] == seStim[s])); // R10
  end

endmodule

// File: rtl/acjtag_out_driver.sv
module acjtag_out_driver
  import acjtag_pkg::*;
#(
  parameter int NUM_PORTS      = 2,
  parameter int LANES_PER_PORT = 2,
  parameter int NUM_SE         = 2,
  localparam int NUM_LANES     = NUM_PORTS * LANES_PER_PORT
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic [1:0]           instrSel,
  input  logic                 rtiState,
  input  logic                 bsShift,
  input  logic                 bsCapture,
  input  logic                 bsUpdate,
  input  logic                 scanIn,
  output logic                 scanOut,
  input  logic [NUM_LANES-1:0] laneStim,
  input  logic [NUM_LANES-1:0] laneFunc,
  input  logic [NUM_SE-1:0]    seStim,
  input  logic [NUM_SE-1:0]    seFunc,
  output logic [NUM_LANES-1:0] laneP,
  output logic [NUM_LANES-1:0] laneN,
  output logic [NUM_SE-1:0]    seOut
);

  laneCtl_t [NUM_PORTS-1:0] portCtl;
  logic                     seDrive;

  acjtag_ctrl #(
    .NUM_PORTS(NUM_PORTS)
  ) ctrl_i (
    .tck      (tck),
    .trstN    (trstN),
    .instrSel (instrSel),
    .rtiState (rtiState),
    .bsShift  (bsShift),
    .bsCapture(bsCapture),
    .bsUpdate (bsUpdate),
    .scanIn   (scanIn),
    .scanOut  (scanOut),
    .portCtl  (portCtl),
    .seDrive  (seDrive)
  );

  acjtag_dpath #(
    .NUM_PORTS     (NUM_PORTS),
    .LANES_PER_PORT(LANES_PER_PORT),
    .NUM_SE        (NUM_SE)
  ) dpath_i (
    .tck     (tck),
    .trstN   (trstN),
    .portCtl (portCtl),
    .seDrive (seDrive),
    .laneStim(laneStim),
    .laneFunc(laneFunc),
    .seStim  (seStim),
    .seFunc  (seFunc),
    .laneP   (laneP),
    .laneN   (laneN),
    .seOut   (seOut)
  );

  AST_PAIR_OPPOSITE: assert property (@(negedge tck) disable iff (!trstN)
    (laneP ^ laneN) == '1); // R11

endmodule

// File: tb/acjtag_out_driver_tb_top.sv
module acjtag_out_driver_tb_top;

  localparam int TCK_PERIOD = 20;
  localparam int HALF       = TCK_PERIOD / 2;
  localparam int WATCHDOG   = 100000;

  logic       tck = 1'b0;
  logic       trstN = 1'b0;
  logic [1:0] instrSel = 2'd0;
  logic       rtiState = 1'b0;
  logic       bsShift = 1'b0;
  logic       bsCapture = 1'b0;
  logic       bsUpdate = 1'b0;
  logic       scanIn = 1'b0;
  logic       scanOut;
  logic [3:0] laneStim = 4'b0000;
  logic [3:0] laneFunc = 4'b0000;
  logic [1:0] seStim = 2'b00;
  logic [1:0] seFunc = 2'b00;
  logic [3:0] laneP;
  logic [3:0] laneN;
  logic [1:0] seOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(HALF) tck = ~tck;

  acjtag_out_driver dut_i (
    .tck(tck), .trstN(trstN), .instrSel(instrSel), .rtiState(rtiState),
    .bsShift(bsShift), .bsCapture(bsCapture), .bsUpdate(bsUpdate),
    .scanIn(scanIn), .scanOut(scanOut), .laneStim(laneStim),
    .laneFunc(laneFunc), .seStim(seStim), .seFunc(seFunc),
    .laneP(laneP), .laneN(laneN), .seOut(seOut)
  );

  function automatic logic [3:0] portMask(input logic [1:0] portInv);
    return {{2{portInv[1]}}, {2{portInv[0]}}};
  endfunction

  task automatic chkLanes(input string req, input logic [3:0] expP);
    checks++;
    if (laneP !== expP || laneN !== ~expP) begin
      errors++;
      $display("FAIL %s: laneP=%b laneN=%b expected laneP=%b laneN=%b",
               req, laneP, laneN, expP, ~expP);
    end
  endtask

  task automatic chkSe(input string req, input logic [1:0] expSe);
    checks++;
    if (seOut !== expSe) begin
      errors++;
      $display("FAIL %s: seOut=%b expected %b", req, seOut, expSe);
    end
  endtask

  task automatic chkBit(input string req, input logic act, input logic expV);
    checks++;
    if (act !== expV) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, expV);
    end
  endtask

  task automatic atRise();
    @(posedge tck);
    #2;
  endtask

  task automatic afterFall();
    @(negedge tck);
    #2;
  endtask

  // Loads port1 first, then port0
  task automatic loadSel(input logic p1, input logic p0);
    atRise(); bsShift = 1'b1; scanIn = p1;
    atRise(); scanIn = p0;
    atRise(); bsShift = 1'b0; bsUpdate = 1'b1;
    atRise(); bsUpdate = 1'b0;
  endtask

  task automatic readSel(input string req, input logic p1, input logic p0);
    atRise(); bsCapture = 1'b1;
    atRise(); bsCapture = 1'b0;
    chkBit({req, " port1 select"}, scanOut, p1);
    bsShift = 1'b1;
    atRise(); bsShift = 1'b0;
    chkBit({req, " port0 select"}, scanOut, p0);
  endtask

  task automatic testReset();
    chkBit("R4 chain after reset", scanOut, 1'b0);
    chkLanes("R1 lanes after reset", laneFunc);
    chkSe("R1 single-ended after reset", seFunc);
  endtask

  task automatic testFunc();
    atRise(); instrSel = 2'd0; laneFunc = 4'b1010; seFunc = 2'b01;
    laneStim = 4'b0101; rtiState = 1'b1;
    #3 chkLanes("R1 functional pattern A", 4'b1010);
    chkSe("R1 functional single-ended A", 2'b01);
    atRise(); laneFunc = 4'b0011; seFunc = 2'b10;
    #3 chkLanes("R11 functional pattern B", 4'b0011);
    atRise(); rtiState = 1'b0;
  endtask

  task automatic testChain();
    loadSel(1'b1, 1'b0);
    readSel("R3", 1'b1, 1'b0);
    loadSel(1'b0, 1'b1);
    readSel("R3", 1'b0, 1'b1);
  endtask

  task automatic testExtest();
    loadSel(1'b1, 1'b1);
    atRise(); instrSel = 2'd1; laneStim = 4'b0110; seStim = 2'b10;
    #3 chkLanes("R2 extest before idle", 4'b0110);
    atRise(); rtiState = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      afterFall();
      chkLanes("R2 extest static in idle", 4'b0110);
      chkSe("R10 extest single-ended", 2'b10);
    end
    atRise(); rtiState = 1'b0;
  endtask

  task automatic testPulseAc();
    loadSel(1'b1, 1'b1);
    atRise(); instrSel = 2'd2; laneStim = 4'b0110; seStim = 2'b01;
    #3 chkLanes("R6 pulse before idle normal", 4'b0110);
    atRise(); rtiState = 1'b1;
    #3 chkLanes("R6 pulse inverted on entry", 4'b1001);
    for (int k = 1; k <= 3; k++) begin
      afterFall();
      chkLanes("R6 pulse held inverted", 4'b1001);
      chkSe("R10 pulse single-ended", 2'b01);
    end
    atRise(); rtiState = 1'b0;
    #3 chkLanes("R7 pulse restored on exit", 4'b0110);
    afterFall();
    chkLanes("R7 pulse stays restored", 4'b0110);
  endtask

  task automatic testTrainAc();
    loadSel(1'b1, 1'b1);
    atRise(); instrSel = 2'd3; laneStim = 4'b1100; seStim = 2'b11;
    atRise(); rtiState = 1'b1;
    #3 chkLanes("R8 train normal on entry", 4'b1100);
    for (int k = 1; k <= 5; k++) begin
      afterFall();
      chkLanes("R8 train alternation", (k % 2 == 1) ? 4'b0011 : 4'b1100);
      chkSe("R10 train single-ended", 2'b11);
    end
    atRise(); rtiState = 1'b0;
    #3 chkLanes("R9 train restored on exit", 4'b1100);
    afterFall();
    chkLanes("R9 train stays restored", 4'b1100);
    atRise(); rtiState = 1'b1;
    #3 chkLanes("R9 train restarts normal", 4'b1100);
    afterFall();
    chkLanes("R8 train first edge inverts", 4'b0011);
    atRise(); rtiState = 1'b0;
  endtask

  task automatic testDc();
    loadSel(1'b0, 1'b0);
    atRise(); instrSel = 2'd2; laneStim = 4'b1011;
    atRise(); rtiState = 1'b1;
    #3 chkLanes("R5 pulse on DC ports", 4'b1011);
    afterFall();
    chkLanes("R5 pulse on DC ports after edge", 4'b1011);
    atRise(); rtiState = 1'b0; instrSel = 2'd3;
    atRise(); rtiState = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      afterFall();
      chkLanes("R5 train on DC ports", 4'b1011);
    end
    atRise(); rtiState = 1'b0;
  endtask

  task automatic testMixed();
    loadSel(1'b1, 1'b0);
    atRise(); instrSel = 2'd3; laneStim = 4'b0101;
    atRise(); rtiState = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      afterFall();
      chkLanes("R12 mixed ports train",
               4'b0101 ^ portMask((k % 2 == 1) ? 2'b10 : 2'b00));
    end
    atRise(); instrSel = 2'd2;
    #3 chkLanes("R12 mixed ports pulse", 4'b0101 ^ portMask(2'b10));
    atRise(); rtiState = 1'b0;
  endtask

  task automatic testResetClear();
    loadSel(1'b1, 1'b1);
    atRise(); trstN = 1'b0;
    #3 chkBit("R4 chain cleared in reset", scanOut, 1'b0);
    atRise(); trstN = 1'b1;
    readSel("R4 after reset", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #2 trstN = 1'b1;
    #3 testReset();
    testFunc();
    testChain();
    testExtest();
    testPulseAc();
    testTrainAc();
    testDc();
    testMixed();
    testResetClear();
    atRise();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge tck);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule